// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block is a data cache controller that sits between a processor request port and a main-memory port that moves whole blocks. Each line holds a valid flag, a dirty flag, a tag and one data block. The word address is split into three fields. The low field picks the word inside the block, the next field picks the line, and the upper field is the tag. A processor request that hits is served from the line in the same cycle. A read returns the selected word. A write merges the enabled byte lanes into the line and marks it dirty, and memory is left untouched.

On a miss the processor is held off by keeping `cpu_ready` low. If the line being replaced is both valid and dirty, its block is first written to memory at the block address rebuilt from the stored tag and the index. The requested block is then read, installed with valid set and dirty cleared, and the controller returns to lookup. The request the processor is still holding is then replayed and hits, so a write miss ends as a write hit that dirties the freshly installed line. Memory commands use a request/ready handshake and complete on a one-cycle done pulse.

Top module: `cwb_cache`

## Requirements
- R1: With the default configuration, word address bits [1:0] select the word in a block, bits [4:2] select the line and bits [9:5] form the tag. The memory block address is the word address without its two lowest bits.
- R2: A request that hits raises `cpu_ready` in the same cycle it is presented, and `cpu_ready` is never high without `cpu_req`. On a read hit, `cpu_rdata` is the addressed word of the line.
- R3: A write hit updates exactly the byte lanes whose `cpu_be` bit is set (lane k is `cpu_wdata[8k+7:8k]`) and marks the line dirty. It starts no memory command.
- R4: From the cycle a miss is seen until the replayed access completes, `cpu_ready` stays low and the processor is stalled.
- R5: On a miss whose line is valid and dirty, a memory write (`mem_we`=1) of the whole old block is issued to address {stored tag, index}. The refill read follows directly after that write's done pulse.
- R6: On a miss whose line is invalid or clean, no memory write is issued, and the refill read is the only memory command.
- R7: A refill reads the requested block address and installs that block with the new tag, valid set and dirty cleared. The held request is then replayed: a read returns the refilled word in the cycle after the done pulse, and a write merges its bytes and dirties the line.
- R8: After reset every line is invalid and clean, so `cpu_ready` and `mem_req` are low, and the first access to each line misses without a write-back.
- R9: `mem_req`, `mem_we` and `mem_baddr` stay steady until `mem_rdy` accepts the command. `mem_req` stays low while an accepted command awaits `mem_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_waddr | input | WADDR_W | Word address |
| cpu_be | input | WORD_W/8 | Byte-lane enables for writes |
| cpu_wdata | input | WORD_W | Write data |
| cpu_rdata | output | WORD_W | Read data, valid when `cpu_ready` is high on a read |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Memory command valid |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_baddr | output | WADDR_W-log2(BLK_WORDS) | Memory block address |
| mem_wdata | output | WORD_W*BLK_WORDS | Block written back |
| mem_rdy | input | 1 | Memory accepts the command |
| mem_rdata | input | WORD_W*BLK_WORDS | Block returned by a read |
| mem_done | input | 1 | One-cycle pulse ending the accepted command |

## Verification
Two events can meet back to back: the install of a refilled block, which clears dirty, and the replayed write, which sets dirty on that same line in the next cycle. The bench provokes this by issuing write misses both to clean lines and to dirty lines across all indexes and several tags. It then forces those lines out again with reads to other tags. It judges the result by whether the later write-back occurs at all, and whether its block carries the merged bytes that a memory model kept in the bench predicts.

// File: rtl/cwb_pkg.sv
package cwb_pkg;

   typedef enum logic [2:0] {
      MS_IDLE    = 3'd0,
      MS_WB_REQ  = 3'd1,
      MS_WB_WAIT = 3'd2,
      MS_RF_REQ  = 3'd3,
      MS_RF_WAIT = 3'd4
   } miss_state_e;

endpackage

// File: rtl/cwb_addr_split.sv
module cwb_addr_split #(
   parameter int WADDR_W = 10,
   parameter int WSEL_W  = 2,
   parameter int IDX_W   = 3,
   parameter int TAG_W   = 5,
   parameter int BADDR_W = 8
) (
   input  logic [WADDR_W-1:0] waddr,
   output logic [TAG_W-1:0]   tag,
   output logic [IDX_W-1:0]   idx,
   output logic [WSEL_W-1:0]  wsel,
   output logic [BADDR_W-1:0] baddr
);

   // word select lowest, line index above it, tag on top
   assign wsel  = waddr[WSEL_W-1:0];
   assign idx   = waddr[WSEL_W +: IDX_W];
   assign tag   = waddr[WADDR_W-1 -: TAG_W];
   assign baddr = waddr[WADDR_W-1 -: BADDR_W];

endmodule

// File: rtl/cwb_line_store.sv
module cwb_line_store #(
   parameter int LINES     = 8,
   parameter int TAG_W     = 5,
   parameter int WORD_W    = 32,
   parameter int BLK_WORDS = 4,
   parameter int IDX_W     = $clog2(LINES),
   parameter int WSEL_W    = $clog2(BLK_WORDS),
   parameter int LANES     = WORD_W / 8,
   parameter int BLK_W     = WORD_W * BLK_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WSEL_W-1:0] wsel,
   input  logic              wr_en,
   input  logic [LANES-1:0]  wr_be,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              fill_en,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [BLK_W-1:0]  fill_block,
   output logic              line_valid,
   output logic              line_dirty,
   output logic [TAG_W-1:0]  line_tag,
   output logic [BLK_W-1:0]  line_block
);

   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q  [LINES];
   logic [BLK_W-1:0] data_q [LINES];
   logic [BLK_W-1:0] merged;

   assign line_valid = valid_q[idx];
   assign line_dirty = dirty_q[idx];
   assign line_tag   = tag_q[idx];
   assign line_block = data_q[idx];

   // byte-lane merge of the write word into the addressed block
   for (genvar w = 0; w < BLK_WORDS; w++) begin : g_word
      for (genvar b = 0; b < LANES; b++) begin : g_lane
         assign merged[(w*LANES + b)*8 +: 8] =
            (wsel == WSEL_W'(w) && wr_be[b]) ? wr_data[b*8 +: 8]
                                             : line_block[(w*LANES + b)*8 +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (fill_en) begin
         valid_q[idx] <= 1'b1;
         dirty_q[idx] <= 1'b0;
      end else if (wr_en) begin
         dirty_q[idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[idx]  <= fill_tag;
         data_q[idx] <= fill_block;
      end else if (wr_en) begin
         data_q[idx] <= merged;
      end
   end

endmodule

// File: rtl/cwb_miss_fsm.sv
module cwb_miss_fsm
   import cwb_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        lookup,
   input  logic        hit,
   input  logic        victim_dirty,
   input  logic        mem_rdy,
   input  logic        mem_done,
   output miss_state_e state,
   output logic        mem_req,
   output logic        mem_we,
   output logic        fill_en
);

   miss_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         MS_IDLE:    if (lookup && !hit)
                        state_d = victim_dirty ? MS_WB_REQ : MS_RF_REQ;
         MS_WB_REQ:  if (mem_rdy)  state_d = MS_WB_WAIT;
         MS_WB_WAIT: if (mem_done) state_d = MS_RF_REQ;
         MS_RF_REQ:  if (mem_rdy)  state_d = MS_RF_WAIT;
         MS_RF_WAIT: if (mem_done) state_d = MS_IDLE;
         default:    state_d = MS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= MS_IDLE;
      else        state_q <= state_d;
   end

   assign state   = state_q;
   assign mem_req = (state_q == MS_WB_REQ) || (state_q == MS_RF_REQ);
   assign mem_we  = (state_q == MS_WB_REQ);
   assign fill_en = (state_q == MS_RF_WAIT) && mem_done;

endmodule

// File: rtl/cwb_cache.sv
module cwb_cache
   import cwb_pkg::*;
#(
   parameter int WADDR_W   = 10,
   parameter int WORD_W    = 32,
   parameter int BLK_WORDS = 4,
   parameter int LINES     = 8
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      cpu_req,
   input  logic                                      cpu_we,
   input  logic [WADDR_W-1:0]                        cpu_waddr,
   input  logic [WORD_W/8-1:0]                       cpu_be,
   input  logic [WORD_W-1:0]                         cpu_wdata,
   output logic [WORD_W-1:0]                         cpu_rdata,
   output logic                                      cpu_ready,
   output logic                                      mem_req,
   output logic                                      mem_we,
   output logic [WADDR_W-$clog2(BLK_WORDS)-1:0]      mem_baddr,
   output logic [WORD_W*BLK_WORDS-1:0]               mem_wdata,
   input  logic                                      mem_rdy,
   input  logic [WORD_W*BLK_WORDS-1:0]               mem_rdata,
   input  logic                                      mem_done
);

   localparam int LANES   = WORD_W / 8;
   localparam int WSEL_W  = $clog2(BLK_WORDS);
   localparam int IDX_W   = $clog2(LINES);
   localparam int TAG_W   = WADDR_W - WSEL_W - IDX_W;
   localparam int BADDR_W = WADDR_W - WSEL_W;
   localparam int BLK_W   = WORD_W * BLK_WORDS;

   // elaboration-time parameter checks
   if (BLK_WORDS < 2 || (1 << WSEL_W) != BLK_WORDS) begin : g_bad_blk
      $error("cwb_cache: BLK_WORDS must be a power of two of at least 2");
   end
   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("cwb_cache: LINES must be a power of two of at least 2");
   end
   if (WORD_W < 8 || (WORD_W % 8) != 0) begin : g_bad_word
      $error("cwb_cache: WORD_W must be a whole number of bytes");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("cwb_cache: address too narrow to leave a tag");
   end

   logic [TAG_W-1:0]   req_tag;
   logic [IDX_W-1:0]   req_idx;
   logic [WSEL_W-1:0]  req_wsel;
   logic [BADDR_W-1:0] req_baddr;

   logic               line_valid, line_dirty;
   logic [TAG_W-1:0]   line_tag;
   logic [BLK_W-1:0]   line_block;
   logic               hit, fill_en, wr_hit;
   miss_state_e        state;

   cwb_addr_split #(
      .WADDR_W(WADDR_W), .WSEL_W(WSEL_W), .IDX_W(IDX_W),
      .TAG_W(TAG_W), .BADDR_W(BADDR_W)
   ) u_split (
      .waddr(cpu_waddr), .tag(req_tag), .idx(req_idx),
      .wsel(req_wsel), .baddr(req_baddr)
   );

   cwb_line_store #(
      .LINES(LINES), .TAG_W(TAG_W), .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .idx(req_idx), .wsel(req_wsel),
      .wr_en(wr_hit), .wr_be(cpu_be), .wr_data(cpu_wdata),
      .fill_en(fill_en), .fill_tag(req_tag), .fill_block(mem_rdata),
      .line_valid(line_valid), .line_dirty(line_dirty),
      .line_tag(line_tag), .line_block(line_block)
   );

   cwb_miss_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .lookup(cpu_req), .hit(hit),
      .victim_dirty(line_valid && line_dirty),
      .mem_rdy(mem_rdy), .mem_done(mem_done), .state(state),
      .mem_req(mem_req), .mem_we(mem_we), .fill_en(fill_en)
   );

   assign hit       = line_valid && (line_tag == req_tag);
   assign cpu_ready = cpu_req && hit && (state == MS_IDLE);
   assign wr_hit    = cpu_ready && cpu_we;

   // word selection out of the addressed block
   logic [WORD_W-1:0] blk_words [BLK_WORDS];
   for (genvar g = 0; g < BLK_WORDS; g++) begin : g_rd
      assign blk_words[g] = line_block[g*WORD_W +: WORD_W];
   end
   assign cpu_rdata = blk_words[req_wsel];

   // victim address during write-back, requested block otherwise
   assign mem_baddr = (state == MS_WB_REQ || state == MS_WB_WAIT)
                      ? {line_tag, req_idx} : req_baddr;
   assign mem_wdata = line_block;

endmodule

// File: rtl/cwb_cache_chk.sv
module cwb_cache_chk #(
   parameter int BADDR_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cpu_req,
   input logic               cpu_ready,
   input logic               mem_req,
   input logic               mem_we,
   input logic [BADDR_W-1:0] mem_baddr,
   input logic               mem_rdy,
   input logic               mem_done
);

   logic acc_we;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                acc_we <= 1'b0;
      else if (mem_req && mem_rdy) acc_we <= mem_we;
   end

   p_ready_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req);

   p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !mem_req);

   p_stall_during_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cpu_ready);

   p_fill_follows_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_done && acc_we) |=> (mem_req && !mem_we));

   p_replay_hits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_done && !acc_we && cpu_req) |=> cpu_ready);

   p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_we) && $stable(mem_baddr)));

endmodule

bind cwb_cache cwb_cache_chk #(.BADDR_W(BADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
   .mem_req(mem_req), .mem_we(mem_we), .mem_baddr(mem_baddr),
   .mem_rdy(mem_rdy), .mem_done(mem_done)
);

// File: tb/test_cwb_cache.sv
`timescale 1ns/1ps
module test_cwb_cache;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_req = 1'b0, cpu_we = 1'b0;
   logic [9:0]   cpu_waddr = '0;
   logic [3:0]   cpu_be = '0;
   logic [31:0]  cpu_wdata = '0;
   logic [31:0]  cpu_rdata;
   logic         cpu_ready;
   logic         mem_req, mem_we;
   logic [7:0]   mem_baddr;
   logic [127:0] mem_wdata;
   logic         mem_rdy = 1'b0;
   logic [127:0] mem_rdata = '0;
   logic         mem_done = 1'b0;

   always #4 clk = ~clk;

   cwb_cache i_cwb_cache (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_waddr(cpu_waddr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .mem_req(mem_req),
      .mem_we(mem_we), .mem_baddr(mem_baddr), .mem_wdata(mem_wdata),
      .mem_rdy(mem_rdy), .mem_rdata(mem_rdata), .mem_done(mem_done)
   );

   int n_chk = 0, n_fail = 0;
   bit done_flag = 0;

   logic [31:0] bmem [256][4];
   int          wb_cnt = 0, rd_cnt = 0;
   logic [7:0]  last_wb_addr, last_rd_addr;
   logic [127:0] last_wb_data;

   logic        ref_v [8];
   logic        ref_d [8];
   logic [4:0]  ref_tag [8];
   logic [31:0] ref_blk [8][4];

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] pack_mem(input int b);
      logic [127:0] r;
      for (int w = 0; w < 4; w++) r[w*32 +: 32] = bmem[b][w];
      return r;
   endfunction

   function automatic logic [127:0] pack_ref(input int i);
      logic [127:0] r;
      for (int w = 0; w < 4; w++) r[w*32 +: 32] = ref_blk[i][w];
      return r;
   endfunction

   // memory responder: one command at a time, latency varies with address
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && mem_req) begin
            logic        c_we;
            logic [7:0]  c_a;
            logic [127:0] c_d;
            c_we = mem_we; c_a = mem_baddr; c_d = mem_wdata;
            mem_rdy = 1'b1;
            @(negedge clk);
            mem_rdy = 1'b0;
            if (c_we) begin
               for (int w = 0; w < 4; w++) bmem[c_a][w] = c_d[w*32 +: 32];
               wb_cnt++; last_wb_addr = c_a; last_wb_data = c_d;
            end else begin
               rd_cnt++; last_rd_addr = c_a;
            end
            for (int k = 0; k < 1 + int'(c_a % 3); k++) begin
               chk(mem_req == 1'b0, "R9 no second command in flight",
                   128'(mem_req), 128'(0));
               @(negedge clk);
            end
            mem_rdata = c_we ? '0 : pack_mem(int'(c_a));
            mem_done = 1'b1;
            @(negedge clk);
            mem_done = 1'b0;
         end
      end
   end

   task automatic access(input logic we, input logic [9:0] wa, input logic [3:0] be,
                         input logic [31:0] wd);
      logic [2:0] idx; logic [4:0] tag; logic [1:0] ws; logic [7:0] ba;
      bit exp_hit, exp_wb; logic [7:0] exp_wb_addr; logic [127:0] exp_wb_data;
      int wb0, rd0, cyc; logic [31:0] got, expw;
      ws = wa[1:0]; idx = wa[4:2]; tag = wa[9:5]; ba = wa[9:2];
      exp_hit = ref_v[idx] && ref_tag[idx] == tag;
      exp_wb  = !exp_hit && ref_v[idx] && ref_d[idx];
      exp_wb_addr = {ref_tag[idx], idx};
      exp_wb_data = pack_ref(int'(idx));
      wb0 = wb_cnt; rd0 = rd_cnt;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_waddr = wa; cpu_be = be; cpu_wdata = wd;
      #1;
      cyc = 0;
      while (!cpu_ready && cyc < 200) begin
         @(negedge clk); #1; cyc++;
      end
      got = cpu_rdata;
      @(posedge clk); #1;
      cpu_req = 1'b0;
      if (exp_hit) chk(cyc == 0, "R2 hit completes at once", 128'(cyc), 128'(0));
      else chk(cyc > 2 && cyc < 200, "R4 miss stalls until refill", 128'(cyc), 128'(3));
      chk(wb_cnt - wb0 == int'(exp_wb), exp_wb ? "R5 dirty victim written back"
                                               : "R6 no write-back of clean line",
          128'(wb_cnt - wb0), 128'(exp_wb));
      if (exp_wb) begin
         chk(last_wb_addr == exp_wb_addr, "R5 write-back address",
             128'(last_wb_addr), 128'(exp_wb_addr));
         chk(last_wb_data == exp_wb_data, "R5 write-back data",
             last_wb_data, exp_wb_data);
      end
      chk(rd_cnt - rd0 == int'(!exp_hit), "R7 one refill per miss",
          128'(rd_cnt - rd0), 128'(!exp_hit));
      if (!exp_hit) begin
         chk(last_rd_addr == ba, "R1 refill block address",
             128'(last_rd_addr), 128'(ba));
         for (int w = 0; w < 4; w++) ref_blk[idx][w] = bmem[ba][w];
         ref_tag[idx] = tag; ref_v[idx] = 1'b1; ref_d[idx] = 1'b0;
      end
      if (we) begin
         for (int b = 0; b < 4; b++)
            if (be[b]) ref_blk[idx][ws][b*8 +: 8] = wd[b*8 +: 8];
         ref_d[idx] = 1'b1;
      end else begin
         expw = ref_blk[idx][ws];
         chk(got == expw, exp_hit ? "R2 read hit word" : "R7 replayed read word",
             128'(got), 128'(expw));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int b = 0; b < 256; b++)
         for (int w = 0; w < 4; w++)
            bmem[b][w] = {8'hC3, 8'(b), 8'(w * 17), 8'(b ^ (w << 6))};
      for (int i = 0; i < 8; i++) begin
         ref_v[i] = 1'b0; ref_d[i] = 1'b0; ref_tag[i] = '0;
         for (int w = 0; w < 4; w++) ref_blk[i][w] = '0;
      end
      repeat (3) @(negedge clk);
      chk(cpu_ready == 1'b0, "R8 ready low after reset", 128'(cpu_ready), 128'(0));
      chk(mem_req == 1'b0, "R8 no memory command after reset", 128'(mem_req), 128'(0));
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R8/R1/R7: first reads of every word at tag 0 (each line misses once)
      for (int i = 0; i < 32; i++) access(1'b0, 10'(i), 4'h0, 32'h0);
      // R3: write hits on every word, walking all byte-enable patterns
      for (int i = 0; i < 32; i++)
         access(1'b1, 10'(i), 4'(i % 16), 32'h1111_1111 * 32'(i + 1));
      for (int i = 0; i < 32; i++) access(1'b0, 10'(i), 4'h0, 32'h0);
      // R5: dirty victims forced out by tag 1 reads
      for (int l = 0; l < 8; l++) access(1'b0, 10'(32 + l * 4 + (l % 4)), 4'h0, 32'h0);
      // R6/R7: write misses on clean lines (tag 2), then evicted again (tag 3)
      for (int l = 0; l < 8; l++)
         access(1'b1, 10'(64 + l * 4 + ((l + 1) % 4)), 4'(15 - l), 32'hA5C3_0000 + 32'(l));
      for (int l = 0; l < 8; l++) access(1'b0, 10'(96 + l * 4), 4'h0, 32'h0);
      // R5/R7: write misses on dirty lines across tags and indexes
      for (int t = 4; t < 8; t++)
         for (int l = 0; l < 8; l++) begin
            access(1'b1, 10'(t * 32 + l * 4 + (t % 4)), 4'b0101, 32'(t * 256 + l));
            access(1'b1, 10'(((t + 3) % 32) * 32 + l * 4), 4'hF, 32'(~(t + l)));
         end
      // data persistence: reread tag 0 and tag 2 from memory
      for (int i = 0; i < 32; i++) access(1'b0, 10'(i), 4'h0, 32'h0);
      for (int i = 64; i < 96; i++) access(1'b0, 10'(i), 4'h0, 32'h0);

      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule